// File: doc/BRIEF.md
# UART Register Front End with Byte Queues and Interrupt Pulse

This block is the host-facing half of a serial port. A processor reaches it through a simple 32-bit register bus with a byte address and single-cycle read and write strobes. Writes to the data offset queue bytes for transmission, and reads of the same offset drain received bytes. Further registers hold the line control byte, the modem-control byte and the baud divisor, and report status flags, queue flags and both queue occupancies. A key register clears the whole block when it is written with one specific value.

The bit-level transceiver, or a testbench standing in for it, sits on a sideband port. It pops transmit bytes from the head of the transmit queue, pushes received bytes into the receive queue, and reports line errors on four one-cycle inputs. The line control byte and the baud divisor are brought out for that transceiver.

A received byte raises the receive-pending flag only after a long, fixed delay. The interrupt output is a pulse of fixed width. It starts whenever the gated interrupt condition goes from false to true.

Top module: `uart_fifo_ctrl`

## Requirements
- R1: Offsets decode as follows. 0x04 writes the line control byte, which appears on `line_ctrl`, and reads back the status byte. 0x08 is modem control, 0x0C is the baud divisor, 0x14 is the transmit occupancy and 0x18 is the receive occupancy. Reads of 0x1C, 0x24, 0x28 or any other unlisted offset return 0, and writes there change nothing.
- R2: A write of exactly 0x00000055 to offset 0x20 empties both queues and returns every register to its reset value, the key register included. Any other value, such as 0xAA, is stored in the key register, reads back, and clears nothing.
- R3: The status byte has these bits: bit0 parity, bit1 framing, bit2 overrun, bit3 break, bit5 transmit done, bit6 transmit queue empty and bit7 receive pending. Bit 4 reads 0. After reset the status byte is 0x40.
- R4: The queue-status byte at 0x10 has these bits: bit0 TX empty, bit1 TX low, bit2 TX full, bit3 TX high, bit4 RX empty, bit5 RX low, bit6 RX full and bit7 RX high. A low flag means the queue is not empty and holds at most a quarter of its depth. A high flag means it holds at least three quarters of its depth. After reset the byte is 0x11.
- R5: A push into a full queue is discarded, and that queue's occupancy stays at its depth.
- R6: The interrupt condition is modem-control bit2 AND (transmit done OR receive pending OR any error bit). One cycle after the condition rises, `irq` goes high for exactly IRQ_PULSE cycles. While bit2 is clear, `irq` stays low.
- R7: While modem-control bit5 is clear, sideband receive pushes are ignored.
- R8: A write of zero to the baud divisor is ignored. A nonzero write is stored and appears on `baud_div`.
- R9: A sideband pop that empties the transmit queue sets transmit done. A host write to offset 0x00 clears transmit done.
- R10: A host read that empties the receive queue clears overrun and receive pending.
- R11: Receive pending is set RX_DELAY cycles after the clock edge that accepts a byte into an idle receive timer.
- R12: A host read of offset 0x00 while the receive queue is empty returns 0 and changes no state.
- R13: The parity, framing and break flags stay set until a reset. Overrun stays set until the receive queue is drained.
- R14: Both queues deliver bytes in the order they were pushed. The occupancy registers report the exact byte counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid combinationally during the read cycle |
| tx_pop | input | 1 | Transceiver takes the transmit head byte |
| tx_data | output | 8 | Transmit head byte |
| tx_valid | output | 1 | Transmit queue is not empty |
| rx_push | input | 1 | Transceiver delivers a received byte |
| rx_data | input | 8 | Received byte |
| err_parity | input | 1 | Parity error seen |
| err_frame | input | 1 | Framing error seen |
| err_overrun | input | 1 | Overrun seen |
| err_break | input | 1 | Break or fragment seen |
| line_ctrl | output | 8 | Stored line control byte |
| baud_div | output | BAUD_W | Stored baud divisor |
| irq | output | 1 | Interrupt pulse |

## Verification
The bench uses a configuration with 8-deep queues, a 20-cycle receive delay and a 4-cycle pulse. It steps each queue through every occupancy from empty to past full, and at each step checks the queue-status byte against flags computed from the count. This separates the quarter and three-quarter thresholds from the empty and full edges, and shows that the ninth push is dropped.

Both queues are drained byte by byte to confirm the push order. The receive delay is probed one cycle before and one cycle at its expiry, and the interrupt width is counted over a window. Error pulses and key writes are interleaved with queue traffic to tell sticky flags apart from flags that clear on a drain or on a soft clear.

// File: rtl/uart_fifo_ctrl_pkg.sv
package uart_fifo_ctrl_pkg;

   // register offsets (byte addresses)
   localparam logic [7:0] OFS_DATA  = 8'h00;
   localparam logic [7:0] OFS_CTRL  = 8'h04;
   localparam logic [7:0] OFS_MODEM = 8'h08;
   localparam logic [7:0] OFS_BAUD  = 8'h0C;
   localparam logic [7:0] OFS_FSTAT = 8'h10;
   localparam logic [7:0] OFS_TXCNT = 8'h14;
   localparam logic [7:0] OFS_RXCNT = 8'h18;
   localparam logic [7:0] OFS_KEY   = 8'h20;

   localparam logic [31:0] KEY_CLEAR = 32'h0000_0055;

   // modem-control bit positions
   localparam int MDM_IRQ_EN = 2;
   localparam int MDM_RX_EN  = 5;

   // status byte, bit7 first
   typedef struct packed {
      logic rx_pend;
      logic tx_empty;
      logic tx_done;
      logic spare;
      logic brk;
      logic ovr;
      logic frm;
      logic par;
   } stat_t;

endpackage

// File: rtl/uart_byte_fifo.sv
module uart_byte_fifo #(
   parameter int DEPTH = 16,
   parameter int W     = 8,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          push,
   input  logic [W-1:0]  din,
   input  logic          pop,
   output logic [W-1:0]  dout,
   output logic [CW-1:0] count,
   output logic          empty,
   output logic          full,
   output logic          low,
   output logic          high
);
   localparam int LOW_MARK  = DEPTH / 4;
   localparam int HIGH_MARK = DEPTH - DEPTH / 4;

   generate
      if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("uart_byte_fifo: DEPTH must be a power of two and at least 4");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic          do_push, do_pop;

   assign empty   = (count == '0);
   assign full    = (count == CW'(DEPTH));
   assign low     = !empty && (count <= CW'(LOW_MARK));
   assign high    = (count >= CW'(HIGH_MARK));
   assign do_pop  = pop && !empty;
   assign do_push = push && (!full || do_pop);
   assign dout    = mem[rd_ptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (clr) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (do_push && !clr) mem[wr_ptr] <= din;
   end

   // R5
   full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop && !clr && count == CW'(DEPTH)) |=> (count == CW'(DEPTH)));

   // R14
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));

endmodule

// File: rtl/uart_rx_delay.sv
module uart_rx_delay #(
   parameter int DELAY = 240000,
   localparam int TW   = $clog2(DELAY + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic arm,
   input  logic cancel,
   output logic fire
);
   generate
      if (DELAY < 1) begin : g_bad_delay
         $error("uart_rx_delay: DELAY must be at least 1");
      end
   endgenerate

   logic          busy;
   logic [TW-1:0] tmr;

   assign fire = busy && (tmr == TW'(DELAY - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         tmr  <= '0;
      end else if (clr || cancel) begin
         busy <= 1'b0;
         tmr  <= '0;
      end else if (busy) begin
         if (fire) begin
            busy <= 1'b0;
            tmr  <= '0;
         end else begin
            tmr <= tmr + 1'b1;
         end
      end else if (arm) begin
         busy <= 1'b1;
         tmr  <= '0;
      end
   end

   // R11
   idle_timer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (tmr == '0));

endmodule

// File: rtl/uart_irq_pulse.sv
module uart_irq_pulse #(
   parameter int PULSE = 24
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic cond,
   output logic irq
);
   generate
      if (PULSE == 0) begin : g_level
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   irq_q <= 1'b0;
            else if (clr) irq_q <= 1'b0;
            else          irq_q <= cond;
         end
         assign irq = irq_q;
      end else begin : g_pulse
         localparam int CW = $clog2(PULSE + 1);
         logic          cond_q;
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cond_q <= 1'b0;
               cnt    <= '0;
            end else if (clr) begin
               cond_q <= 1'b0;
               cnt    <= '0;
            end else begin
               cond_q <= cond;
               if (cond && !cond_q) cnt <= CW'(PULSE);
               else if (cnt != '0)  cnt <= cnt - 1'b1;
            end
         end
         assign irq = (cnt != '0);

         // R6
         irq_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq) |-> $past(cond));

         if (PULSE > 1) begin : g_width
            // R6
            irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
               $rose(irq) |=> irq);
         end
      end
   endgenerate

endmodule

// File: rtl/uart_fifo_ctrl.sv
module uart_fifo_ctrl
   import uart_fifo_ctrl_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int BAUD_W    = 16,
   parameter int TX_DEPTH  = 2048,
   parameter int RX_DEPTH  = 1024,
   parameter int RX_DELAY  = 240000,
   parameter int IRQ_PULSE = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              tx_pop,
   output logic [7:0]        tx_data,
   output logic              tx_valid,
   input  logic              rx_push,
   input  logic [7:0]        rx_data,
   input  logic              err_parity,
   input  logic              err_frame,
   input  logic              err_overrun,
   input  logic              err_break,
   output logic [7:0]        line_ctrl,
   output logic [BAUD_W-1:0] baud_div,
   output logic              irq
);
   localparam int TXC_W = $clog2(TX_DEPTH) + 1;
   localparam int RXC_W = $clog2(RX_DEPTH) + 1;

   generate
      if (ADDR_W < 6) begin : g_bad_addr
         $error("uart_fifo_ctrl: ADDR_W must cover the 0x28-byte window");
      end
      if (BAUD_W < 1 || BAUD_W > 32) begin : g_bad_baud
         $error("uart_fifo_ctrl: BAUD_W must be 1..32");
      end
   endgenerate

   // register state
   logic [7:0]        ctrl_q, mdm_q, key_q;
   logic [BAUD_W-1:0] baud_q;
   logic [3:0]        err_q;          // 0 par, 1 frm, 2 ovr, 3 brk
   logic              tx_done, rx_pend;

   // address decode
   logic sel_data, sel_ctrl, sel_mdm, sel_baud, sel_key;
   assign sel_data = (bus_addr == ADDR_W'(OFS_DATA));
   assign sel_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
   assign sel_mdm  = (bus_addr == ADDR_W'(OFS_MODEM));
   assign sel_baud = (bus_addr == ADDR_W'(OFS_BAUD));
   assign sel_key  = (bus_addr == ADDR_W'(OFS_KEY));

   logic soft_clr, host_push, host_pop;
   assign soft_clr  = bus_wr && sel_key && (bus_wdata == KEY_CLEAR);
   assign host_push = bus_wr && sel_data;
   assign host_pop  = bus_rd && sel_data;

   // queues
   logic [TXC_W-1:0] tx_cnt;
   logic [RXC_W-1:0] rx_cnt;
   logic [7:0]       rx_head;
   logic tx_empty, tx_full, tx_low, tx_high;
   logic rx_empty, rx_full, rx_low, rx_high;
   logic rx_acc, rx_drain, rx_fire;

   assign rx_acc   = rx_push && mdm_q[MDM_RX_EN] && (!rx_full || (host_pop && !rx_empty));
   assign rx_drain = host_pop && (rx_cnt == RXC_W'(1)) && !rx_acc;

   uart_byte_fifo #(.DEPTH(TX_DEPTH), .W(8)) u_tx_fifo (
      .clk(clk), .rst_n(rst_n), .clr(soft_clr),
      .push(host_push), .din(bus_wdata[7:0]), .pop(tx_pop), .dout(tx_data),
      .count(tx_cnt), .empty(tx_empty), .full(tx_full), .low(tx_low), .high(tx_high)
   );

   uart_byte_fifo #(.DEPTH(RX_DEPTH), .W(8)) u_rx_fifo (
      .clk(clk), .rst_n(rst_n), .clr(soft_clr),
      .push(rx_push && mdm_q[MDM_RX_EN]), .din(rx_data), .pop(host_pop), .dout(rx_head),
      .count(rx_cnt), .empty(rx_empty), .full(rx_full), .low(rx_low), .high(rx_high)
   );

   uart_rx_delay #(.DELAY(RX_DELAY)) u_rx_delay (
      .clk(clk), .rst_n(rst_n), .clr(soft_clr),
      .arm(rx_acc), .cancel(rx_drain), .fire(rx_fire)
   );

   // control and status registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         mdm_q   <= '0;
         key_q   <= '0;
         baud_q  <= '0;
         err_q   <= '0;
         tx_done <= 1'b0;
         rx_pend <= 1'b0;
      end else if (soft_clr) begin
         ctrl_q  <= '0;
         mdm_q   <= '0;
         key_q   <= '0;
         baud_q  <= '0;
         err_q   <= '0;
         tx_done <= 1'b0;
         rx_pend <= 1'b0;
      end else begin
         if (bus_wr && sel_ctrl) ctrl_q <= bus_wdata[7:0];
         if (bus_wr && sel_mdm)  mdm_q  <= bus_wdata[7:0];
         if (bus_wr && sel_key)  key_q  <= bus_wdata[7:0];
         if (bus_wr && sel_baud && bus_wdata != '0) baud_q <= bus_wdata[BAUD_W-1:0];

         err_q[0] <= err_q[0] | err_parity;
         err_q[1] <= err_q[1] | err_frame;
         err_q[2] <= (err_q[2] & !rx_drain) | err_overrun;
         err_q[3] <= err_q[3] | err_break;

         if (host_push)
            tx_done <= 1'b0;
         else if (tx_pop && tx_cnt == TXC_W'(1))
            tx_done <= 1'b1;

         if (rx_drain)     rx_pend <= 1'b0;
         else if (rx_fire) rx_pend <= 1'b1;
      end
   end

   stat_t      st;
   logic [7:0] fstat;
   logic       irq_cond;

   assign st       = {rx_pend, tx_empty, tx_done, 1'b0, err_q[3], err_q[2], err_q[1], err_q[0]};
   assign fstat    = {rx_high, rx_full, rx_low, rx_empty, tx_high, tx_full, tx_low, tx_empty};
   assign irq_cond = mdm_q[MDM_IRQ_EN] && (tx_done || rx_pend || (|err_q));

   uart_irq_pulse #(.PULSE(IRQ_PULSE)) u_irq (
      .clk(clk), .rst_n(rst_n), .clr(soft_clr), .cond(irq_cond), .irq(irq)
   );

   // read mux
   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         ADDR_W'(OFS_DATA):  bus_rdata = rx_empty ? 32'd0 : {24'd0, rx_head};
         ADDR_W'(OFS_CTRL):  bus_rdata = {24'd0, st};
         ADDR_W'(OFS_MODEM): bus_rdata = {24'd0, mdm_q};
         ADDR_W'(OFS_BAUD):  bus_rdata = 32'(baud_q);
         ADDR_W'(OFS_FSTAT): bus_rdata = {24'd0, fstat};
         ADDR_W'(OFS_TXCNT): bus_rdata = 32'(tx_cnt);
         ADDR_W'(OFS_RXCNT): bus_rdata = 32'(rx_cnt);
         ADDR_W'(OFS_KEY):   bus_rdata = {24'd0, key_q};
         default:            bus_rdata = '0;
      endcase
   end

   assign tx_valid  = !tx_empty;
   assign line_ctrl = ctrl_q;
   assign baud_div  = baud_q;

   // R2
   soft_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_clr |=> (tx_cnt == '0 && rx_cnt == '0 && mdm_q == '0 && baud_q == '0));

   // R7
   rx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_push && !mdm_q[MDM_RX_EN] && !host_pop && !soft_clr) |=> $stable(rx_cnt));

   // R8
   baud_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && sel_baud && bus_wdata == '0) |=> $stable(baud_q));

   // R11
   pend_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_pend) |-> (rx_cnt != '0));

   // R10
   drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_pop && rx_cnt == RXC_W'(1) && !rx_push && !soft_clr) |=> (rx_cnt == '0 && !st.rx_pend));

   // R9
   tx_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_pop && tx_cnt == TXC_W'(1) && !host_push && !soft_clr) |=> (st.tx_done && st.tx_empty));

endmodule

// File: tb/uart_fifo_ctrl_tb.sv
module uart_fifo_ctrl_tb;
   localparam int TXD = 8;
   localparam int RXD = 8;
   localparam int DLY = 20;
   localparam int PLS = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        tx_pop = 1'b0;
   logic [7:0]  tx_data;
   logic        tx_valid;
   logic        rx_push = 1'b0;
   logic [7:0]  rx_data = '0;
   logic        err_parity = 1'b0, err_frame = 1'b0, err_overrun = 1'b0, err_break = 1'b0;
   logic [7:0]  line_ctrl;
   logic [15:0] baud_div;
   logic        irq;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   uart_fifo_ctrl #(.ADDR_W(8), .BAUD_W(16), .TX_DEPTH(TXD), .RX_DEPTH(RXD),
                    .RX_DELAY(DLY), .IRQ_PULSE(PLS)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_pop(tx_pop), .tx_data(tx_data),
      .tx_valid(tx_valid), .rx_push(rx_push), .rx_data(rx_data), .err_parity(err_parity),
      .err_frame(err_frame), .err_overrun(err_overrun), .err_break(err_break),
      .line_ctrl(line_ctrl), .baud_div(baud_div), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // every task starts at a falling edge and consumes exactly one rising edge
   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a; bus_rd = 1'b1;
      #4 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic rchk(input string req, input logic [7:0] a, input logic [31:0] exp);
      logic [31:0] d;
      rd(a, d);
      chk(req, d, exp);
   endtask

   task automatic push_rx(input logic [7:0] d);
      rx_data = d; rx_push = 1'b1;
      @(negedge clk);
      rx_push = 1'b0;
   endtask

   task automatic pop_tx(output logic [7:0] d);
      d = tx_data; tx_pop = 1'b1;
      @(negedge clk);
      tx_pop = 1'b0;
   endtask

   task automatic pulse_err(input int which);
      err_parity  = (which == 0);
      err_frame   = (which == 1);
      err_overrun = (which == 2);
      err_break   = (which == 3);
      @(negedge clk);
      err_parity = 1'b0; err_frame = 1'b0; err_overrun = 1'b0; err_break = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [31:0] efst(input int t, input int r);
      logic [7:0] f;
      f[0] = (t == 0);
      f[1] = (t != 0) && (t <= TXD / 4);
      f[2] = (t == TXD);
      f[3] = (t >= TXD - TXD / 4);
      f[4] = (r == 0);
      f[5] = (r != 0) && (r <= RXD / 4);
      f[6] = (r == RXD);
      f[7] = (r >= RXD - RXD / 4);
      return {24'd0, f};
   endfunction

   task automatic count_irq(input int win, output int hi);
      hi = 0;
      for (int k = 0; k < win; k++) begin
         if (irq) hi++;
         @(negedge clk);
      end
   endtask

   task automatic finish_run;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
   end

   initial begin
      logic [7:0] b;
      logic [31:0] d;
      int hi;
      int n;

      idle(3);
      rst_n = 1'b1;
      idle(1);

      // reset state
      rchk("R3 status reset", 8'h04, 32'h40);
      rchk("R4 fstat reset", 8'h10, 32'h11);
      chk("R6 irq idle", {31'd0, irq}, 32'd0);
      chk("R14 tx_valid reset", {31'd0, tx_valid}, 32'd0);

      // register map
      wr(8'h04, 32'h1B);
      chk("R1 line_ctrl", {24'd0, line_ctrl}, 32'h1B);
      rchk("R1 0x04 reads status", 8'h04, 32'h40);
      wr(8'h08, 32'h24);
      rchk("R1 modem readback", 8'h08, 32'h24);
      wr(8'h08, 32'h20);
      wr(8'h0C, 32'd200);
      rchk("R1 baud readback", 8'h0C, 32'd200);
      chk("R8 baud_div", {16'd0, baud_div}, 32'd200);
      wr(8'h0C, 32'd0);
      rchk("R8 zero ignored", 8'h0C, 32'd200);
      wr(8'h1C, 32'hFF);
      wr(8'h28, 32'hFF);
      rchk("R1 unmapped 0x1C", 8'h1C, 32'd0);
      rchk("R1 unmapped 0x24", 8'h24, 32'd0);
      rchk("R1 unmapped 0x28", 8'h28, 32'd0);
      rchk("R1 modem kept", 8'h08, 32'h20);
      rchk("R1 baud kept", 8'h0C, 32'd200);

      // empty receive read
      rchk("R12 empty read", 8'h00, 32'd0);
      rchk("R12 count kept", 8'h18, 32'd0);
      rchk("R12 fstat kept", 8'h10, 32'h11);

      // transmit sweep across every occupancy
      for (int i = 1; i <= TXD + 1; i++) begin
         n = (i > TXD) ? TXD : i;
         wr(8'h00, 32'hA0 + i);
         rchk("R14 tx count", 8'h14, n);
         rchk("R4 tx fstat", 8'h10, efst(n, 0));
      end
      rchk("R5 tx full kept", 8'h14, TXD);
      rchk("R9 push clears empty", 8'h04, 32'h00);
      for (int i = 1; i <= TXD; i++) begin
         pop_tx(b);
         chk("R14 tx order", {24'd0, b}, 32'hA0 + i);
         rchk("R4 tx fstat drain", 8'h10, efst(TXD - i, 0));
      end
      rchk("R9 done on empty", 8'h04, 32'h60);
      chk("R14 tx_valid empty", {31'd0, tx_valid}, 32'd0);
      wr(8'h00, 32'h77);
      rchk("R9 host push clears done", 8'h04, 32'h00);
      pop_tx(b);
      chk("R14 single byte", {24'd0, b}, 32'h77);
      rchk("R9 done again", 8'h04, 32'h60);

      // reset key
      wr(8'h20, 32'hAA);
      rchk("R2 key stored", 8'h20, 32'hAA);
      rchk("R2 no clear on AA", 8'h04, 32'h60);
      wr(8'h00, 32'h12);
      wr(8'h20, 32'h55);
      rchk("R2 status cleared", 8'h04, 32'h40);
      rchk("R2 fstat cleared", 8'h10, 32'h11);
      rchk("R2 tx count cleared", 8'h14, 32'd0);
      rchk("R2 modem cleared", 8'h08, 32'd0);
      rchk("R2 baud cleared", 8'h0C, 32'd0);
      rchk("R2 key cleared", 8'h20, 32'd0);
      chk("R2 line_ctrl cleared", {24'd0, line_ctrl}, 32'd0);

      // receive gated off
      push_rx(8'h33);
      rchk("R7 push ignored", 8'h18, 32'd0);
      idle(DLY + 2);
      rchk("R7 no pending", 8'h04, 32'h40);

      // receive delay and interrupt pulse
      wr(8'h08, 32'h24);
      chk("R6 no irq without cause", {31'd0, irq}, 32'd0);
      push_rx(8'h51);
      idle(DLY - 1);
      rchk("R11 pending not yet", 8'h04, 32'h40);
      rchk("R11 pending at delay", 8'h04, 32'hC0);
      count_irq(12, hi);
      chk("R6 pulse width", hi, PLS);

      // receive sweep to past full
      for (int i = 2; i <= RXD + 1; i++) begin
         n = (i > RXD) ? RXD : i;
         push_rx(8'h50 + 8'(i));
         rchk("R14 rx count", 8'h18, n);
         rchk("R4 rx fstat", 8'h10, efst(0, n));
      end
      rchk("R5 rx full kept", 8'h18, RXD);

      pulse_err(0);
      pulse_err(2);
      rchk("R13 errors set", 8'h04, 32'hC5);
      for (int i = 1; i <= RXD; i++) begin
         rd(8'h00, d);
         chk("R14 rx order", d, 32'h50 + i);
         rchk("R4 rx fstat drain", 8'h10, efst(0, RXD - i));
      end
      rchk("R10 drain clears overrun and pending", 8'h04, 32'h41);
      idle(DLY + 4);
      rchk("R10 no late pending", 8'h04, 32'h41);
      rchk("R12 empty read again", 8'h00, 32'd0);
      rchk("R12 status kept", 8'h04, 32'h41);
      pulse_err(3);
      idle(5);
      rchk("R13 sticky parity and break", 8'h04, 32'h49);

      // interrupt gating by modem-control bit2
      wr(8'h20, 32'h55);
      wr(8'h08, 32'h20);
      pulse_err(1);
      rchk("R13 framing set", 8'h04, 32'h42);
      count_irq(10, hi);
      chk("R6 gated off", hi, 0);
      wr(8'h08, 32'h24);
      count_irq(10, hi);
      chk("R6 pulse on enable", hi, PLS);

      finish_run();
   end

endmodule